// File: doc/BRIEF.md
# Precision Time-of-Day Clock with Trim and Step

This block keeps a running time of day as a seconds count and a nanoseconds count. The nanoseconds count advances by a fixed nominal amount on every reference clock cycle. It wraps at one billion and carries into the seconds count. Software never touches the live counters directly. It works through a set of shadow registers and a one-shot action field:

- **Capture** copies the live time into the shadows.
- **Load** copies the shadows into the live time.
- **Step** adds a signed nanosecond offset held in the shadow nanoseconds register to the live time in a single cycle.

A trim unit lets the clock follow a reference. It accumulates elapsed time in picoseconds or nanoseconds, as software selects. Each time a programmed period has elapsed, that cycle's increment is raised or lowered by one nanosecond. Software derives the period from the wanted rate error, roughly 10^12 divided by the parts-per-billion value. The live time is also brought out on ports, for local consumers such as a timestamping unit.

Register map:

| Address | Register | Fields |
|---|---|---|
| 0 | Control | bit 0: run |
| 1 | Action | bits 1:0 |
| 2 | Shadow nanoseconds | bits 29:0 |
| 3 | Shadow seconds, low word | bits 31:0 |
| 4 | Shadow seconds, upper part | bits SEC_HI_W-1:0 |
| 5 | Trim period | bits 29:0 period, bit 30 unit (1 = nanoseconds, 0 = picoseconds) |
| 6 | Trim config | bit 0: enable, bit 1: direction (1 = lose time) |

Action codes: 0 is idle, 1 is capture, 2 is load, 3 is step. Reads return the register contents, zero-extended.

Top module: `tod_clock`

## Requirements
- R1: After reset the live time and all shadow registers are zero, and the live time does not advance while the run bit (address 0 bit 0) is clear.
- R2: With run set, the nanoseconds output advances by INC_NS on every clock edge, starting with the edge after the control write.
- R3: When the nanoseconds value would reach 1,000,000,000 or more, it wraps by that amount and the seconds count increases by one in the same cycle.
- R4: An action written to address 1 executes on the next clock edge, and the action register then reads 0 (idle). Load (code 2) makes the live time equal to the shadow registers on that edge.
- R5: Capture (code 1) copies the nanoseconds and both seconds words of the live time, as they stood on one and the same edge, into the shadow registers. A capture issued n cycles after a load returns the loaded value plus n·INC_NS.
- R6: Step (code 3) adds the shadow nanoseconds value, read as a 30-bit two's-complement number, plus that cycle's nominal increment, to the live time. A negative result borrows one second and adds 1,000,000,000 to the nanoseconds.
- R7: A positive step that carries the nanoseconds past 999,999,999 wraps them and increases the seconds by one.
- R8: With trim enabled and the unit bit set, the period counts nanoseconds. Every period-th cycle after the config write uses an increment of INC_NS+1 (direction 0) or INC_NS−1 (direction 1).
- R9: With the unit bit clear, the period counts picoseconds, at INC_NS·1000 ps per cycle, and the one-nanosecond correction applies at the same elapsed-period points.
- R10: Writing 0 to the trim config register stops all corrections from the next cycle on, and it reads back 0.
- R11: The seconds count is split into a 32-bit low word and a SEC_HI_W-bit upper part. A carry out of the low word propagates into the upper part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one nominal increment per edge |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| liveSec | output | 32+SEC_HI_W | Live seconds count |
| liveNs | output | 30 | Live nanoseconds count |

## Verification
The bench uses the defaults, INC_NS = 8 and SEC_HI_W = 16. With an 8 ns step, a 40 ns trim period gives a correction every fifth cycle, and a 24000 ps period gives one every third cycle. Both patterns, in both directions, repeat several times within a few dozen cycles. A load of 999,999,990 ns with the low seconds word all ones reaches the second wrap, and the carry into the upper seconds part, two edges later. A capture issued just then proves that the three shadow words are taken together.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NS_W   = 30;
  localparam int ADDR_W = 3;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_SAVE  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_DELTA = 2'd3
  } todAction_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ACTION = 3'd1;
  localparam logic [ADDR_W-1:0] A_SHNS   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SHSLO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_SHSHI  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd5;
  localparam logic [ADDR_W-1:0] A_ADJCFG = 3'd6;

  typedef struct packed {
    logic run;
    logic save;
    logic load;
    logic delta;
    logic tick;
    logic tickDn;
    logic wrShNs;
    logic wrShSecLo;
    logic wrShSecHi;
  } todStrobe_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int INC_NS   = 8,
  parameter int SEC_HI_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [NS_W-1:0]   shNs,
  input  logic [31:0]       shSecLo,
  input  logic [SEC_HI_W-1:0] shSecHi,
  output todStrobe_t        strb
);
  localparam logic [31:0] STEP_NS = 32'(INC_NS);
  localparam logic [31:0] STEP_PS = 32'(INC_NS * 1000);

  logic       runQ;
  todAction_e actionQ;
  logic [NS_W-1:0] periodQ;
  logic       unitQ;
  logic       adjEnQ;
  logic       adjDirQ;
  logic [31:0] accQ;

  logic wrCtrl, wrAction, wrPeriod, wrCfg;
  logic [31:0] step, accSum, periodExt;
  logic corrOn, tickHit;
  logic unusedBits;

  assign wrCtrl   = regWe && (regAddr == A_CTRL);
  assign wrAction = regWe && (regAddr == A_ACTION);
  assign wrPeriod = regWe && (regAddr == A_PERIOD);
  assign wrCfg    = regWe && (regAddr == A_ADJCFG);
  assign unusedBits = regWdata[31];

  assign step      = unitQ ? STEP_NS : STEP_PS;
  assign periodExt = {2'b00, periodQ};
  assign accSum    = accQ + step;
  assign corrOn    = runQ && adjEnQ && (periodQ != '0);
  assign tickHit   = corrOn && (accSum >= periodExt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      actionQ <= ACT_IDLE;
      periodQ <= '0;
      unitQ   <= 1'b0;
      adjEnQ  <= 1'b0;
      adjDirQ <= 1'b0;
      accQ    <= '0;
    end else begin
      if (wrCtrl) runQ <= regWdata[0];
      if (wrAction) actionQ <= todAction_e'(regWdata[1:0]);
      else          actionQ <= ACT_IDLE;
      if (wrPeriod) {unitQ, periodQ} <= regWdata[30:0];
      if (wrCfg) {adjDirQ, adjEnQ} <= regWdata[1:0];
      if (wrPeriod || wrCfg) accQ <= '0;
      else if (tickHit)      accQ <= accSum - periodExt;
      else if (corrOn)       accQ <= accSum;
    end
  end

  always_comb begin
    strb           = '0;
    strb.run       = runQ;
    strb.save      = (actionQ == ACT_SAVE);
    strb.load      = (actionQ == ACT_LOAD);
    strb.delta     = (actionQ == ACT_DELTA);
    strb.tick      = tickHit;
    strb.tickDn    = adjDirQ;
    strb.wrShNs    = regWe && (regAddr == A_SHNS);
    strb.wrShSecLo = regWe && (regAddr == A_SHSLO);
    strb.wrShSecHi = regWe && (regAddr == A_SHSHI);
  end

  always_comb begin
    case (regAddr)
      A_CTRL:   regRdata = {31'd0, runQ};
      A_ACTION: regRdata = {30'd0, actionQ};
      A_SHNS:   regRdata = {2'd0, shNs};
      A_SHSLO:  regRdata = shSecLo;
      A_SHSHI:  regRdata = 32'(shSecHi);
      A_PERIOD: regRdata = {1'b0, unitQ, periodQ};
      A_ADJCFG: regRdata = {30'd0, adjDirQ, adjEnQ};
      default:  regRdata = '0;
    endcase
  end

  // R4
  action_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actionQ != ACT_IDLE && !wrAction) |=> (actionQ == ACT_IDLE));

  // R10
  tick_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCfg && !regWdata[0]) |=> !strb.tick);
endmodule

// File: rtl/tod_dp.sv
module tod_dp
  import tod_pkg::*;
#(
  parameter int INC_NS   = 8,
  parameter int SEC_HI_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  todStrobe_t           strb,
  input  logic [31:0]          regWdata,
  output logic [NS_W-1:0]      shNs,
  output logic [31:0]          shSecLo,
  output logic [SEC_HI_W-1:0]  shSecHi,
  output logic [NS_W-1:0]      liveNs,
  output logic [32+SEC_HI_W-1:0] liveSec
);
  localparam int SEC_W = 32 + SEC_HI_W;
  localparam logic signed [32:0] NSPS_S = 33'sd1000000000;

  logic [NS_W-1:0]     nsQ, shNsQ, nsNext;
  logic [SEC_W-1:0]    secQ, secNext;
  logic [31:0]         shLoQ;
  logic [SEC_HI_W-1:0] shHiQ;
  logic signed [32:0]  incS, offS, sumS, fixS;

  always_comb begin
    incS = '0;
    if (strb.run) begin
      incS = 33'(INC_NS);
      if (strb.tick) incS = strb.tickDn ? (incS - 33'sd1) : (incS + 33'sd1);
    end
    offS = strb.delta ? {{3{shNsQ[NS_W-1]}}, shNsQ} : '0;
    sumS = $signed({3'b000, nsQ}) + incS + offS;
    if (sumS < 33'sd0) begin
      fixS    = sumS + NSPS_S;
      secNext = secQ - SEC_W'(1);
    end else if (sumS >= NSPS_S) begin
      fixS    = sumS - NSPS_S;
      secNext = secQ + SEC_W'(1);
    end else begin
      fixS    = sumS;
      secNext = secQ;
    end
    nsNext = fixS[NS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nsQ  <= '0;
      secQ <= '0;
    end else if (strb.load) begin
      nsQ  <= shNsQ;
      secQ <= {shHiQ, shLoQ};
    end else begin
      nsQ  <= nsNext;
      secQ <= secNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shNsQ <= '0;
      shLoQ <= '0;
      shHiQ <= '0;
    end else if (strb.save) begin
      shNsQ <= nsQ;
      shLoQ <= secQ[31:0];
      shHiQ <= secQ[SEC_W-1:32];
    end else begin
      if (strb.wrShNs)    shNsQ <= regWdata[NS_W-1:0];
      if (strb.wrShSecLo) shLoQ <= regWdata;
      if (strb.wrShSecHi) shHiQ <= regWdata[SEC_HI_W-1:0];
    end
  end

  assign shNs    = shNsQ;
  assign shSecLo = shLoQ;
  assign shSecHi = shHiQ;
  assign liveNs  = nsQ;
  assign liveSec = secQ;

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && nsQ < NS_PER_SEC) |=> (nsQ < NS_PER_SEC));

  // R3
  carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.delta && nsQ < NS_PER_SEC) |=>
      ((nsQ < $past(nsQ)) == (secQ == $past(secQ) + SEC_W'(1))));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (nsQ == $past(shNsQ) && secQ == $past({shHiQ, shLoQ})));

  // R5
  save_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.save |=> (shNsQ == $past(nsQ) && {shHiQ, shLoQ} == $past(secQ)));

  // R4
  action_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.save, strb.load, strb.delta}));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int INC_NS   = 8,
  parameter int SEC_HI_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2:0]               regAddr,
  input  logic                     regWe,
  input  logic [31:0]              regWdata,
  output logic [31:0]              regRdata,
  output logic [32+SEC_HI_W-1:0]   liveSec,
  output logic [29:0]              liveNs
);
  todStrobe_t          strb;
  logic [NS_W-1:0]     shNs;
  logic [31:0]         shSecLo;
  logic [SEC_HI_W-1:0] shSecHi;

  tod_ctrl #(.INC_NS(INC_NS), .SEC_HI_W(SEC_HI_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .shNs(shNs),
    .shSecLo(shSecLo), .shSecHi(shSecHi), .strb(strb)
  );

  tod_dp #(.INC_NS(INC_NS), .SEC_HI_W(SEC_HI_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .shNs(shNs), .shSecLo(shSecLo), .shSecHi(shSecHi),
    .liveNs(liveNs), .liveSec(liveSec)
  );
endmodule

// File: tb/tod_clock_tb_top.sv
module tod_clock_tb_top;
  localparam int INC = 8;
  localparam int SHW = 16;
  localparam int SW  = 32 + SHW;
  localparam longint BILLION = 64'd1000000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [SW-1:0] liveSec;
  logic [29:0] liveNs;

  always #5 clk = ~clk;

  tod_clock #(.INC_NS(INC), .SEC_HI_W(SHW)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .liveSec(liveSec), .liveNs(liveNs)
  );

  int cyc = 0;
  int nChecks = 0;
  int nErr = 0;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  typedef struct {
    int     at;
    longint ns;
    longint sec;
    string  req;
  } exp_t;
  exp_t q[$];

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expectAt(input int at, input longint ns, input longint sec, input string req);
    exp_t e;
    e.at = at; e.ns = ns; e.sec = sec; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at == cyc) begin
      exp_t e;
      e = q.pop_front();
      check({e.req, " ns"}, longint'(liveNs), e.ns);
      check({e.req, " sec"}, longint'(liveSec), e.sec);
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output longint d);
    regAddr = a;
    #1;
    d = longint'(regRdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadTime(input longint ns, input longint sec);
    regWrite(3'd2, 32'(ns));
    regWrite(3'd3, sec[31:0]);
    regWrite(3'd4, 32'(sec >> 32));
    regWrite(3'd1, 32'd2);
  endtask

  task automatic finishRun();
    check("end: scoreboard drained", longint'(q.size()), 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    longint rd, base, bsec, s, ssec;
    int ew;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state and no counting while stopped
    idle(5);
    check("R1 ns idle", longint'(liveNs), 0);
    check("R1 sec idle", longint'(liveSec), 0);
    regRead(3'd2, rd); check("R1 shadow ns", rd, 0);
    regRead(3'd3, rd); check("R1 shadow sec lo", rd, 0);

    // R2: nominal increment
    regWrite(3'd0, 32'd1);
    ew = cyc;
    for (int k = 1; k <= 4; k++) expectAt(ew + k, longint'(INC * k), 0, "R2");
    idle(4);

    // R4 / R3 / R11 / R5: load near second end, capture across the carry
    loadTime(999999990, 64'h1_FFFF_FFFF);
    ew = cyc;
    expectAt(ew + 1, 999999990, 64'h1_FFFF_FFFF, "R4 load");
    expectAt(ew + 2, 999999998, 64'h1_FFFF_FFFF, "R3 pre-wrap");
    expectAt(ew + 3, 6, 64'h2_0000_0000, "R3 R11 wrap carry");
    regRead(3'd1, rd); check("R4 action pending", rd, 2);
    idle(1);
    regRead(3'd1, rd); check("R4 action back to idle", rd, 0);
    idle(1);
    regWrite(3'd1, 32'd1);
    idle(1);
    regRead(3'd2, rd); check("R5 capture ns", rd, 6);
    regRead(3'd3, rd); check("R11 capture sec lo", rd, 0);
    regRead(3'd4, rd); check("R11 capture sec hi", rd, 2);

    // R5: capture ten cycles after a load
    loadTime(1000, 7);
    idle(10);
    regWrite(3'd1, 32'd1);
    idle(1);
    regRead(3'd2, rd); check("R5 capture after load ns", rd, 1000 + 10 * INC);
    regRead(3'd3, rd); check("R5 capture after load sec", rd, 7);

    // R6: negative step with borrow
    loadTime(5, 10);
    regWrite(3'd2, 32'h3FFF_FC18);
    regWrite(3'd3, 32'd0);
    regWrite(3'd4, 32'd0);
    regWrite(3'd1, 32'd3);
    ew = cyc;
    base = longint'(liveNs); bsec = longint'(liveSec);
    s = base + INC - 1000; ssec = bsec;
    if (s < 0) begin s += BILLION; ssec -= 1; end
    check("R6 borrow expected", ssec, 9);
    expectAt(ew + 1, s, ssec, "R6 step");
    expectAt(ew + 2, s + INC, ssec, "R6 after step");
    idle(2);

    // R7: positive step with carry
    loadTime(999999000, 3);
    regWrite(3'd2, 32'd2000);
    regWrite(3'd1, 32'd3);
    ew = cyc;
    base = longint'(liveNs); bsec = longint'(liveSec);
    s = base + INC + 2000; ssec = bsec;
    if (s >= BILLION) begin s -= BILLION; ssec += 1; end
    check("R7 carry expected", ssec, 4);
    expectAt(ew + 1, s, ssec, "R7 step");
    idle(1);

    // R8: nanosecond-unit trim, gain
    loadTime(100, 20);
    regWrite(3'd5, 32'h4000_0028);
    regWrite(3'd6, 32'd1);
    ew = cyc;
    base = longint'(liveNs); bsec = longint'(liveSec);
    for (int k = 1; k <= 15; k++) begin
      base += (k % 5 == 0) ? INC + 1 : INC;
      expectAt(ew + k, base, bsec, "R8 gain");
    end
    idle(15);

    // R8: nanosecond-unit trim, lose
    regWrite(3'd6, 32'd3);
    ew = cyc;
    base = longint'(liveNs);
    for (int k = 1; k <= 10; k++) begin
      base += (k % 5 == 0) ? INC - 1 : INC;
      expectAt(ew + k, base, bsec, "R8 lose");
    end
    idle(10);

    // R9: picosecond-unit trim
    regWrite(3'd5, 32'd24000);
    regWrite(3'd6, 32'd1);
    ew = cyc;
    base = longint'(liveNs);
    for (int k = 1; k <= 12; k++) begin
      base += (k % 3 == 0) ? INC + 1 : INC;
      expectAt(ew + k, base, bsec, "R9 ps");
    end
    idle(12);

    // R10: trim disabled
    regWrite(3'd6, 32'd0);
    ew = cyc;
    base = longint'(liveNs);
    for (int k = 1; k <= 12; k++) begin
      base += INC;
      expectAt(ew + k, base, bsec, "R10 off");
    end
    regRead(3'd6, rd); check("R10 config reads zero", rd, 0);
    idle(13);

    finishRun();
  end
endmodule